// File: doc/BRIEF.md
# Serial-Programmed Double-Buffered Synthesizer Configuration Bank

This block is the configuration front end of a frequency synthesizer control core. Software-side logic shifts 32-bit words in over a three-wire port made of a serial clock, a data line and a latch strobe. When the strobe rises, the word that has been collected is stored in one of six configuration registers. The three least significant bits of the word select that register.

The divider and loop settings reach the synthesizer core through two copies. Some fields are double buffered: writing them changes only a pending (shadow) copy. The active copy, which drives the outputs, picks up the pending values only when register 0 is written next. Register 0 holds the integer and fractional divide values. This means a whole retune takes effect on one clock edge. The output-divider select is double buffered only while a mode bit in register 2 is set. The RF output enable can be held low until the lock-detect input reports lock.

The three serial inputs are asynchronous. They are brought into the system clock domain through flop synchronizers, and their rising edges are detected in that domain.

Top module: `serial_cfg_bank`

## Requirements
- R1: On each rising edge of `ser_clk`, the bit on `ser_data` shifts into a 32-bit register at the low end, so the first bit sent ends up as bit 31 (MSB first).
- R2: On a rising edge of `ser_le`, word bits 2:0 select the destination register: 0 to 5 select register 0 to register 5. Registers 3 and 5 carry no fields that reach the outputs.
- R3: A latched word with bits 2:0 equal to 6 or 7 changes no register, active or pending.
- R4: Register 0 carries the fractional value in bits 14:3 (12 bits) and the integer divide value in bits 30:15 (16 bits). Both update the `frac` and `int_n` outputs directly.
- R5: Register 1 (modulus in bits 14:3, phase in bits 26:15) and register 2 (reference count in bits 12:3, charge-pump current in bits 17:14, doubler in bit 18, halver in bit 19) update only pending copies. `modulus`, `phase`, `r_div`, `cp_cur`, `ref_dbl` and `ref_half` do not change on those writes.
- R6: A register 0 write copies every pending value to the active outputs on the same clock edge that updates `int_n` and `frac`.
- R7: Register 4 carries the output-divider select in bits 22:20. When register 2 bit 13 is low, `out_dsel` follows a register 4 write at once.
- R8: When register 2 bit 13 is high, a register 4 write leaves `out_dsel` unchanged. The new select appears at the next register 0 write.
- R9: Register 4 bits 4:3 drive `out_pwr` directly on the register 4 write.
- R10: When register 4 bit 10 (mute until lock) is set, `rf_en` is low while `lock_det` is low and high once `lock_det` is high. When the bit is clear, `rf_en` is high.
- R11: While `rst_n` is low, all outputs are zero, including `rf_en`.
- R12: The configuration outputs reflect a latched word three system clocks after `ser_le` is driven high, and `rf_en` follows one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch strobe, rising edge stores the word |
| lock_det | input | 1 | Lock indication, synchronous to clk |
| r_div | output | 10 | Active reference divider count |
| int_n | output | 16 | Integer divide value |
| frac | output | 12 | Fractional numerator |
| modulus | output | 12 | Active fractional modulus |
| phase | output | 12 | Active phase value |
| ref_dbl | output | 1 | Active reference doubler enable |
| ref_half | output | 1 | Active reference divide-by-two enable |
| cp_cur | output | 4 | Active charge-pump current code |
| out_dsel | output | 3 | Active output divider select |
| out_pwr | output | 2 | Output power level code |
| rf_en | output | 1 | RF output enable after mute-until-lock gating |

## Verification
The assertions assume the following about the inputs:
- Each serial clock phase and each strobe phase lasts longer than the synchronizer depth plus one system clock, so every edge is seen exactly once.
- `ser_data` is stable around each rising edge of the serial clock.
- `lock_det` already belongs to the system clock domain.

The stimulus holds each serial clock and strobe level for four system clocks and changes data only while the serial clock is low. The reference model is compared only after each strobe or lock change has settled.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int WORD_W = 32;
    localparam int CTRL_W = 3;
    localparam int R_W    = 10;
    localparam int INT_W  = 16;
    localparam int FRAC_W = 12;
    localparam int MOD_W  = 12;
    localparam int PH_W   = 12;
    localparam int CP_W   = 4;
    localparam int DSEL_W = 3;
    localparam int PWR_W  = 2;

    // register 0
    localparam int R0_FRAC_LSB = 3;
    localparam int R0_INT_LSB  = R0_FRAC_LSB + FRAC_W;
    // register 1
    localparam int R1_MOD_LSB  = 3;
    localparam int R1_PH_LSB   = R1_MOD_LSB + MOD_W;
    // register 2
    localparam int R2_R_LSB    = 3;
    localparam int R2_MODE_BIT = 13;
    localparam int R2_CP_LSB   = 14;
    localparam int R2_DBL_BIT  = R2_CP_LSB + CP_W;
    localparam int R2_HALF_BIT = R2_DBL_BIT + 1;
    // register 4
    localparam int R4_PWR_LSB  = 3;
    localparam int R4_MUTE_BIT = 10;
    localparam int R4_DSEL_LSB = 20;

    typedef enum logic [CTRL_W-1:0] {
        SEL_R0 = 3'd0,
        SEL_R1 = 3'd1,
        SEL_R2 = 3'd2,
        SEL_R3 = 3'd3,
        SEL_R4 = 3'd4,
        SEL_R5 = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic [MOD_W-1:0]  modv;
        logic [PH_W-1:0]   phase;
        logic [R_W-1:0]    rdiv;
        logic              dbl;
        logic              half;
        logic [CP_W-1:0]   cp;
        logic [DSEL_W-1:0] dsel;
    } buf_set_t;

    typedef struct packed {
        buf_set_t           act;
        buf_set_t           shd;
        logic [INT_W-1:0]   intn;
        logic [FRAC_W-1:0]  frac;
        logic               dsel_mode;
        logic [PWR_W-1:0]   pwr;
        logic               mute;
        logic               rf_en;
    } bank_state_t;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] rise_o
);

    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] pipe;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.pipe[0] = async_i;
        for (int k = 1; k < DEPTH; k++) begin
            state_d.pipe[k] = state_q.pipe[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rise_o = state_q.pipe[STAGES-1] & ~state_q.pipe[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0)); // R1

endmodule

// File: rtl/cfg_shift.sv
module cfg_shift
    import cfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata_i,
    input  logic              shift_en,
    output logic [WORD_W-1:0] word_o
);

    typedef struct packed {
        logic [STAGES-1:0] dpipe;
        logic [WORD_W-1:0] sr;
    } shift_state_t;

    shift_state_t state_d, state_q;
    logic         bit_s;

    assign bit_s = state_q.dpipe[STAGES-1];

    always_comb begin
        state_d = state_q;
        state_d.dpipe = {state_q.dpipe[STAGES-2:0], sdata_i};
        if (shift_en) begin
            state_d.sr = {state_q.sr[WORD_W-2:0], bit_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign word_o = state_q.sr;

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word_o[0] == $past(bit_s))); // R1
    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word_o[WORD_W-1:1] == $past(word_o[WORD_W-2:0]))); // R1
    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word_o)); // R1

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
    import cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              lock_i,
    output bank_state_t       state_o
);

    bank_state_t        state_d, state_q;
    logic [CTRL_W-1:0]  ctrl;

    assign ctrl = word_i[CTRL_W-1:0];

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            case (ctrl)
                SEL_R0: begin
                    state_d.frac = word_i[R0_FRAC_LSB +: FRAC_W];
                    state_d.intn = word_i[R0_INT_LSB +: INT_W];
                    state_d.act  = state_q.shd;
                end
                SEL_R1: begin
                    state_d.shd.modv  = word_i[R1_MOD_LSB +: MOD_W];
                    state_d.shd.phase = word_i[R1_PH_LSB +: PH_W];
                end
                SEL_R2: begin
                    state_d.shd.rdiv  = word_i[R2_R_LSB +: R_W];
                    state_d.shd.cp    = word_i[R2_CP_LSB +: CP_W];
                    state_d.shd.dbl   = word_i[R2_DBL_BIT];
                    state_d.shd.half  = word_i[R2_HALF_BIT];
                    state_d.dsel_mode = word_i[R2_MODE_BIT];
                end
                SEL_R4: begin
                    state_d.pwr      = word_i[R4_PWR_LSB +: PWR_W];
                    state_d.mute     = word_i[R4_MUTE_BIT];
                    state_d.shd.dsel = word_i[R4_DSEL_LSB +: DSEL_W];
                    if (!state_q.dsel_mode) begin
                        state_d.act.dsel = word_i[R4_DSEL_LSB +: DSEL_W];
                    end
                end
                SEL_R3, SEL_R5: begin
                    state_d = state_q;
                end
                default: begin
                    state_d = state_q;
                end
            endcase
        end
        state_d.rf_en = !state_q.mute || lock_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    AST_CODE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && ctrl > 3'd5) |=> ($stable(state_q.act) && $stable(state_q.shd)
            && $stable(state_q.intn) && $stable(state_q.frac) && $stable(state_q.pwr)
            && $stable(state_q.mute) && $stable(state_q.dsel_mode))); // R3
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && (ctrl == 3'd0 || ctrl == 3'd4)) |=> $stable(state_q.act)); // R5
    AST_COMMIT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && ctrl == 3'd0) |=> (state_q.act == $past(state_q.shd))); // R6
    AST_DSEL_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && ctrl == 3'd4 && !state_q.dsel_mode)
            |=> (state_q.act.dsel == $past(word_i[R4_DSEL_LSB +: DSEL_W]))); // R7
    AST_DSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && ctrl == 3'd4 && state_q.dsel_mode) |=> $stable(state_q.act.dsel)); // R8
    AST_MUTE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.mute && !lock_i) |=> !state_q.rf_en); // R10
    AST_UNMUTED_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.mute) |=> state_q.rf_en); // R10

endmodule

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank
    import cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    input  logic              lock_det,
    output logic [R_W-1:0]    r_div,
    output logic [INT_W-1:0]  int_n,
    output logic [FRAC_W-1:0] frac,
    output logic [MOD_W-1:0]  modulus,
    output logic [PH_W-1:0]   phase,
    output logic              ref_dbl,
    output logic              ref_half,
    output logic [CP_W-1:0]   cp_cur,
    output logic [DSEL_W-1:0] out_dsel,
    output logic [PWR_W-1:0]  out_pwr,
    output logic              rf_en
);

    localparam int EDGE_W = 2;
    localparam int IDX_SCLK = 0;
    localparam int IDX_LE   = 1;

    logic [EDGE_W-1:0] edges;
    logic [WORD_W-1:0] word;
    bank_state_t       bank;

    cfg_sync #(
        .WIDTH  (EDGE_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_le, ser_clk}),
        .rise_o  (edges)
    );

    cfg_shift #(
        .STAGES (SYNC_STAGES)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sdata_i  (ser_data),
        .shift_en (edges[IDX_SCLK]),
        .word_o   (word)
    );

    cfg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (edges[IDX_LE]),
        .word_i  (word),
        .lock_i  (lock_det),
        .state_o (bank)
    );

    assign r_div    = bank.act.rdiv;
    assign int_n    = bank.intn;
    assign frac     = bank.frac;
    assign modulus  = bank.act.modv;
    assign phase    = bank.act.phase;
    assign ref_dbl  = bank.act.dbl;
    assign ref_half = bank.act.half;
    assign cp_cur   = bank.act.cp;
    assign out_dsel = bank.act.dsel;
    assign out_pwr  = bank.pwr;
    assign rf_en    = bank.rf_en;

    AST_LOAD_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        edges[IDX_LE] |=> $stable(word)); // R2

endmodule

// File: tb/serial_cfg_bank_tb.sv
module serial_cfg_bank_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0, lock_det = 1'b0;
    logic [9:0]  r_div;
    logic [15:0] int_n;
    logic [11:0] frac, modulus, phase;
    logic        ref_dbl, ref_half, rf_en;
    logic [3:0]  cp_cur;
    logic [2:0]  out_dsel;
    logic [1:0]  out_pwr;

    always #4 clk = ~clk;

    serial_cfg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .lock_det(lock_det), .r_div(r_div), .int_n(int_n),
        .frac(frac), .modulus(modulus), .phase(phase), .ref_dbl(ref_dbl),
        .ref_half(ref_half), .cp_cur(cp_cur), .out_dsel(out_dsel),
        .out_pwr(out_pwr), .rf_en(rf_en)
    );

    int checks = 0, failures = 0, blank = 8;
    bit done = 0;
    string cur_req = "R11";

    // reference model
    int m_int = 0, m_frac = 0, m_pwr = 0, m_mute = 0, m_mode = 0;
    int a_mod = 0, a_ph = 0, a_r = 0, a_dbl = 0, a_half = 0, a_cp = 0, a_ds = 0;
    int s_mod = 0, s_ph = 0, s_r = 0, s_dbl = 0, s_half = 0, s_cp = 0, s_ds = 0;

    function automatic logic [73:0] got_vec();
        return {r_div, int_n, frac, modulus, phase, ref_dbl, ref_half, cp_cur,
                out_dsel, out_pwr, rf_en};
    endfunction

    function automatic logic [73:0] exp_vec();
        logic rf;
        rf = (rst_n == 1'b0) ? 1'b0 : ((m_mute == 0) || lock_det);
        if (!rst_n) return '0;
        return {10'(a_r), 16'(m_int), 12'(m_frac), 12'(a_mod), 12'(a_ph), 1'(a_dbl),
                1'(a_half), 4'(a_cp), 3'(a_ds), 2'(m_pwr), rf};
    endfunction

    task automatic chk(input string req, input logic [73:0] got, input logic [73:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            if (blank > 0) blank--;
            else chk(cur_req, got_vec(), exp_vec());
        end
    end

    task automatic model_apply(input logic [31:0] w);
        case (w[2:0])
            3'd0: begin
                m_frac = int'(w[14:3]); m_int = int'(w[30:15]);
                a_mod = s_mod; a_ph = s_ph; a_r = s_r; a_dbl = s_dbl;
                a_half = s_half; a_cp = s_cp; a_ds = s_ds;
            end
            3'd1: begin s_mod = int'(w[14:3]); s_ph = int'(w[26:15]); end
            3'd2: begin
                s_r = int'(w[12:3]); m_mode = int'(w[13]); s_cp = int'(w[17:14]);
                s_dbl = int'(w[18]); s_half = int'(w[19]);
            end
            3'd4: begin
                m_pwr = int'(w[4:3]); m_mute = int'(w[10]); s_ds = int'(w[22:20]);
                if (m_mode == 0) a_ds = s_ds;
            end
            default: ;
        endcase
    endtask

    task automatic send(input logic [31:0] w, input string req);
        cur_req = req;
        for (int i = 31; i >= 0; i--) begin
            @(posedge clk); #1 ser_data = w[i];
            repeat (4) @(posedge clk); #1 ser_clk = 1'b1;
            repeat (4) @(posedge clk); #1 ser_clk = 1'b0;
        end
        repeat (4) @(posedge clk);
        #1 ser_le = 1'b1; blank = 6; model_apply(w);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R12", got_vec(), exp_vec());
        @(posedge clk); #1 ser_le = 1'b0;
        repeat (4) @(posedge clk);
    endtask

    task automatic set_lock(input logic v, input string req);
        cur_req = req;
        @(posedge clk); #1 lock_det = v; blank = 3;
        repeat (4) @(posedge clk);
    endtask

    function automatic logic [31:0] w0(input int i, input int f);
        return (32'(i) << 15) | (32'(f) << 3);
    endfunction
    function automatic logic [31:0] w1(input int md, input int ph);
        return (32'(ph) << 15) | (32'(md) << 3) | 32'd1;
    endfunction
    function automatic logic [31:0] w2(input int r, input int mode, input int cp,
                                       input int dbl, input int half);
        return (32'(half) << 19) | (32'(dbl) << 18) | (32'(cp) << 14) |
               (32'(mode) << 13) | (32'(r) << 3) | 32'd2;
    endfunction
    function automatic logic [31:0] w4(input int ds, input int mute, input int pwr);
        return (32'(ds) << 20) | (32'(mute) << 10) | (32'(pwr) << 3) | 32'd4;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", got_vec(), '0);
        @(posedge clk); #1 rst_n = 1'b1; blank = 3;
        repeat (6) @(posedge clk);

        send(w0(16'h1234, 12'h5A5), "R4");
        @(negedge clk); chk("R4", {int_n, frac}, {16'h1234, 12'h5A5});
        send(w0(16'hFFFF, 12'hFFF), "R4");
        @(negedge clk); chk("R4", {int_n, frac}, {16'hFFFF, 12'hFFF});
        send(w0(16'h8001, 12'h801), "R1");
        @(negedge clk); chk("R1", {int_n, frac}, {16'h8001, 12'h801});

        send(w1(12'hFFF, 12'h123), "R5");
        @(negedge clk); chk("R5", {modulus, phase}, '0);
        send(w2(10'h3FF, 0, 4'hA, 1, 1), "R5");
        @(negedge clk); chk("R5", {r_div, cp_cur, ref_dbl, ref_half}, '0);
        send(w0(16'h0042, 12'h007), "R6");
        @(negedge clk);
        chk("R6", {modulus, phase, r_div, cp_cur, ref_dbl, ref_half, int_n},
            {12'hFFF, 12'h123, 10'h3FF, 4'hA, 1'b1, 1'b1, 16'h0042});

        send(w1(12'h00F, 12'h00E), "R5");
        send(32'hFFFF_FFFE, "R3");
        send(32'hABCD_EF07, "R3");
        @(negedge clk); chk("R3", {int_n, frac, out_pwr}, {16'h0042, 12'h007, 2'd0});
        send(w0(16'h0100, 12'h000), "R3");
        @(negedge clk); chk("R3", {modulus, phase}, {12'h00F, 12'h00E});

        send(32'hFFFF_FFFB, "R2");
        send(32'hFFFF_FFFD, "R2");
        @(negedge clk); chk("R2", {int_n, modulus, out_pwr}, {16'h0100, 12'h00F, 2'd0});

        send(w4(5, 0, 3), "R7");
        @(negedge clk); chk("R7", {out_dsel, out_pwr}, {3'd5, 2'd3});
        send(w4(5, 0, 1), "R9");
        @(negedge clk); chk("R9", 74'(out_pwr), 74'd1);

        send(w2(10'h001, 1, 4'h3, 0, 1), "R8");
        send(w4(2, 0, 2), "R8");
        @(negedge clk); chk("R8", {out_dsel, out_pwr}, {3'd5, 2'd2});
        send(w0(16'h0200, 12'h010), "R8");
        @(negedge clk); chk("R8", {out_dsel, r_div, cp_cur}, {3'd2, 10'h001, 4'h3});

        send(w4(2, 1, 2), "R10");
        @(negedge clk); chk("R10", 74'(rf_en), 74'd0);
        set_lock(1'b1, "R10");
        @(negedge clk); chk("R10", 74'(rf_en), 74'd1);
        set_lock(1'b0, "R10");
        @(negedge clk); chk("R10", 74'(rf_en), 74'd0);
        send(w4(2, 0, 2), "R10");
        @(negedge clk); chk("R10", 74'(rf_en), 74'd1);

        repeat (10) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog got=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule